// File: doc/BRIEF.md
# External and Pin-Change Interrupt Unit

This unit collects interrupt requests from one dedicated external interrupt input and from twelve pin-change inputs. The pin-change inputs form two groups: group 0 holds inputs 7..0 and group 1 holds inputs 11..8. Each pin-change input has its own mask bit. A group records an event when any of its unmasked inputs changes value. The dedicated input has a two-bit sense field. It can trigger on a low level, on any change, on a falling edge or on a rising edge.

All inputs are synchronized to the always-running system clock. A separate clock-enable input models the gated I/O clock. Edge sensing on the dedicated input needs that enable. Low-level sensing and pin-change sensing do not, so they can still raise a wake request while the enable is low. The detector looks only at pin values. A pin that the chip drives as an output can therefore still raise a request, which gives software a way to force an interrupt.

Edge and change events are held in sticky flags. A flag clears when the CPU acknowledges its vector or when software writes a one to it. The low-level request is not held in a flag; it follows the synchronized pin. Of the pending requests, the unit presents the one with the highest priority as a vector index.

Top module: `xirq_unit`

Register map on the write/read port (two-bit address, eight-bit data):
- address 0, control: bit 0 enables the dedicated input, bit 1 enables group 0, bit 2 enables group 1, bits 4:3 hold the sense field. The upper bits read as zero.
- address 1: group 0 mask. Bit n lets input n contribute.
- address 2: group 1 mask in bits 3:0. Bit n lets input 8+n contribute. The upper bits read as zero.
- address 3: flags. Bit 0 is the dedicated-input edge flag, bit 1 the group 0 flag and bit 2 the group 1 flag. Writing a one to a bit clears that flag.

## Requirements
- R1: After reset, all four registers read zero and irq_req is low.
- R2: When an input in group 0 whose mask bit (address 1) is one changes value, flag bit 1 sets. If group 0 is enabled, irq_req rises with irq_vec = 1.
- R3: A change on a masked-off input sets no flag and raises no request.
- R4: When an input in group 1 (inputs 11..8, mask at address 2) whose mask bit is one changes value, flag bit 2 sets. If group 1 is enabled, irq_req rises with irq_vec = 2.
- R5: With sense 00 and the dedicated input enabled, irq_req is high with irq_vec = 0 while the synchronized pin is low, and low again once the pin is high. No flag is set, an acknowledge does not drop the request, and the I/O clock enable has no effect on it.
- R6: Sense 01 sets flag bit 0 on any change of the dedicated input, sense 10 only on a 1-to-0 change and sense 11 only on a 0-to-1 change.
- R7: An edge on the dedicated input that occurs while io_clk_en is low is lost. Flag bit 0 stays clear, and it stays clear after the enable returns.
- R8: Pin-change flags set while io_clk_en is low.
- R9: A pulse on irq_ack clears the flag of the vector presented in that cycle, and a write of ones to address 3 clears the selected flags.
- R10: The priority runs dedicated input (vector 0) first, then group 0 (vector 1), then group 1 (vector 2). Vector 3 is never presented.
- R11: Flags set whether or not their enable bit is one. Only the request is gated by the enable.
- R12: The control and mask registers read back the written bits, with the bits that do not exist reading as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, always running |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_clk_en | input | 1 | I/O clock enable; edge sensing needs it |
| ext_pin | input | 1 | Dedicated external interrupt input |
| pc_pins | input | 12 | Pin-change inputs; 7..0 are group 0, 11..8 are group 1 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| irq_ack | input | 1 | CPU acknowledge of the presented vector |
| irq_req | output | 1 | Interrupt request toward the CPU |
| irq_vec | output | 2 | Index of the highest-priority pending request |

## Verification
The bench toggles masked and unmasked inputs together. A design that decoded the mask or the group split wrongly would set the wrong flag bit or would flag a masked pin. It sends edges on the dedicated input while the I/O clock enable is low and then raises the enable again. A design that kept a stale previous sample would report an edge after the enable returned. It also checks that the low-level request drops as soon as the pin goes high and survives an acknowledge. A latched design would keep requesting. Finally it raises all three sources at once and acknowledges them one by one. A wrong priority order, or an acknowledge that cleared the wrong flag, would show up as a wrong sequence of vectors.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_t;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_MASK0 = 2'd1;
  localparam logic [1:0] ADDR_MASK1 = 2'd2;
  localparam logic [1:0] ADDR_FLAGS = 2'd3;

  localparam logic [1:0] VEC_EXT = 2'd0;
  localparam logic [1:0] VEC_G0  = 2'd1;
  localparam logic [1:0] VEC_G1  = 2'd2;

  // edge qualification on the dedicated input for a given sense setting
  function automatic logic ext_edge_hit(sense_t s, logic cur, logic prv);
    case (s)
      SENSE_ANY:  return cur ^ prv;
      SENSE_FALL: return prv & ~cur;
      SENSE_RISE: return cur & ~prv;
      default:    return 1'b0;
    endcase
  endfunction

  // fixed priority: bit 0 highest
  function automatic logic [1:0] pick_vec(logic [2:0] pend);
    if (pend[0])      return VEC_EXT;
    else if (pend[1]) return VEC_G0;
    else              return VEC_G1;
  endfunction
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
  import xirq_pkg::*;
#(
  parameter int G0_W = 8,
  parameter int G1_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [7:0]      wr_data,
  input  logic [1:0]      rd_addr,
  input  logic [2:0]      flags,
  output logic [7:0]      rd_data,
  output logic            ext_en,
  output logic            g0_en,
  output logic            g1_en,
  output sense_t          sense,
  output logic [G0_W-1:0] mask0,
  output logic [G1_W-1:0] mask1,
  output logic [2:0]      w1c
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_en <= 1'b0;
      g0_en  <= 1'b0;
      g1_en  <= 1'b0;
      sense  <= SENSE_LOW;
      mask0  <= '0;
      mask1  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_CTRL: begin
          ext_en <= wr_data[0];
          g0_en  <= wr_data[1];
          g1_en  <= wr_data[2];
          sense  <= sense_t'(wr_data[4:3]);
        end
        ADDR_MASK0: mask0 <= wr_data[G0_W-1:0];
        ADDR_MASK1: mask1 <= wr_data[G1_W-1:0];
        default: ;
      endcase
    end
  end

  assign w1c = (wr_en && wr_addr == ADDR_FLAGS) ? wr_data[2:0] : 3'b000;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_CTRL:  rd_data[4:0] = {sense, g1_en, g0_en, ext_en};
      ADDR_MASK0: rd_data[G0_W-1:0] = mask0;
      ADDR_MASK1: rd_data[G1_W-1:0] = mask1;
      default:    rd_data[2:0] = flags;
    endcase
  end
endmodule

// File: rtl/xirq_detect.sv
module xirq_detect
  import xirq_pkg::*;
#(
  parameter int PC_W = 12,
  parameter int G0_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 io_clk_en,
  input  logic                 ext_s,
  input  logic [PC_W-1:0]      pc_s,
  input  sense_t               sense,
  input  logic [G0_W-1:0]      mask0,
  input  logic [PC_W-G0_W-1:0] mask1,
  input  logic [2:0]           clr,
  output logic [2:0]           flags,
  output logic [2:0]           set_evt
);
  logic            ext_prev;
  logic [PC_W-1:0] pc_prev;
  logic [PC_W-1:0] pc_chg;

  // previous samples track the pins continuously so that edges missed
  // while the I/O clock is off are not seen later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_prev <= 1'b0;
      pc_prev  <= '0;
    end else begin
      ext_prev <= ext_s;
      pc_prev  <= pc_s;
    end
  end

  assign pc_chg     = (pc_s ^ pc_prev) & {mask1, mask0};
  assign set_evt[0] = io_clk_en && (sense != SENSE_LOW) && ext_edge_hit(sense, ext_s, ext_prev);
  assign set_evt[1] = |pc_chg[G0_W-1:0];
  assign set_evt[2] = |pc_chg[PC_W-1:G0_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr) | set_evt;
  end
endmodule

// File: rtl/xirq_arb.sv
module xirq_arb
  import xirq_pkg::*;
(
  input  logic [2:0] pend,
  input  logic       irq_ack,
  output logic       irq_req,
  output logic [1:0] irq_vec,
  output logic [2:0] ack_clr
);
  assign irq_req = |pend;
  assign irq_vec = pick_vec(pend);

  always_comb begin
    ack_clr = '0;
    if (irq_ack && irq_req) ack_clr[irq_vec] = 1'b1;
  end
endmodule

// File: rtl/xirq_unit.sv
module xirq_unit
  import xirq_pkg::*;
#(
  parameter int PC_W        = 12,
  parameter int G0_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            io_clk_en,
  input  logic            ext_pin,
  input  logic [PC_W-1:0] pc_pins,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [7:0]      wr_data,
  input  logic [1:0]      rd_addr,
  output logic [7:0]      rd_data,
  input  logic            irq_ack,
  output logic            irq_req,
  output logic [1:0]      irq_vec
);
  localparam int G1_W = PC_W - G0_W;

  logic            ext_s;
  logic [PC_W-1:0] pc_s;
  logic            ext_en, g0_en, g1_en;
  sense_t          sense;
  logic [G0_W-1:0] mask0;
  logic [G1_W-1:0] mask1;
  logic [2:0]      w1c, ack_clr, flags, set_evt, pend;

  xirq_sync #(.W(PC_W + 1), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({ext_pin, pc_pins}), .q({ext_s, pc_s})
  );

  xirq_regs #(.G0_W(G0_W), .G1_W(G1_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .flags(flags), .rd_data(rd_data), .ext_en(ext_en),
    .g0_en(g0_en), .g1_en(g1_en), .sense(sense), .mask0(mask0), .mask1(mask1),
    .w1c(w1c)
  );

  xirq_detect #(.PC_W(PC_W), .G0_W(G0_W)) u_det (
    .clk(clk), .rst_n(rst_n), .io_clk_en(io_clk_en), .ext_s(ext_s), .pc_s(pc_s),
    .sense(sense), .mask0(mask0), .mask1(mask1), .clr(ack_clr | w1c),
    .flags(flags), .set_evt(set_evt)
  );

  // level request follows the pin; edge requests come from flags
  assign pend[0] = ext_en & ((sense == SENSE_LOW) ? ~ext_s : flags[0]);
  assign pend[1] = g0_en & flags[1];
  assign pend[2] = g1_en & flags[2];

  xirq_arb u_arb (
    .pend(pend), .irq_ack(irq_ack), .irq_req(irq_req), .irq_vec(irq_vec),
    .ack_clr(ack_clr)
  );
endmodule

// File: rtl/xirq_unit_chk.sv
module xirq_unit_chk
  import xirq_pkg::*;
#(
  parameter int G0_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            io_clk_en,
  input logic            irq_req,
  input logic [1:0]      irq_vec,
  input logic            irq_ack,
  input logic            ext_en,
  input sense_t          sense,
  input logic            ext_s,
  input logic [2:0]      flags,
  input logic [2:0]      set_evt,
  input logic [2:0]      pend,
  input logic [G0_W-1:0] mask0
);
  p_level_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_en && sense == SENSE_LOW && !ext_s) |-> (irq_req && irq_vec == VEC_EXT));

  p_gated_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[0]) |-> $past(io_clk_en));

  p_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[1]) |-> $past(mask0 != '0));

  p_ack_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req && irq_vec == VEC_G0 && !set_evt[1]) |=> !flags[1]);

  p_prio_ext_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_vec != VEC_EXT) |-> !pend[0]);

  p_prio_g0_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_vec == VEC_G1) |-> !pend[1]);

  p_vec_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> irq_vec != 2'd3);
endmodule

bind xirq_unit xirq_unit_chk #(.G0_W(G0_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_clk_en(io_clk_en), .irq_req(irq_req),
  .irq_vec(irq_vec), .irq_ack(irq_ack), .ext_en(ext_en), .sense(sense),
  .ext_s(ext_s), .flags(flags), .set_evt(set_evt), .pend(pend), .mask0(mask0)
);

// File: tb/xirq_unit_bench.sv
module xirq_unit_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_clk_en = 1'b1;
  logic        ext_pin = 1'b1;
  logic [11:0] pc_pins = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        irq_ack = 1'b0;
  logic        irq_req;
  logic [1:0]  irq_vec;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  xirq_unit u_xirq_unit (
    .clk(clk), .rst_n(rst_n), .io_clk_en(io_clk_en), .ext_pin(ext_pin),
    .pc_pins(pc_pins), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_ack(irq_ack),
    .irq_req(irq_req), .irq_vec(irq_vec)
  );

  function automatic logic [1:0] exp_vec(logic [2:0] p);
    for (int i = 0; i < 3; i++) if (p[i]) return 2'(i);
    return 2'd0;
  endfunction

  function automatic logic [2:0] exp_grp(logic [11:0] o, logic [11:0] n,
                                         logic [7:0] m0, logic [3:0] m1);
    logic [11:0] d;
    d = (o ^ n) & {m1, m0};
    return {(d[11:8] != 0), (d[7:0] != 0), 1'b0};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic ack();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    logic [7:0] d;
    logic [11:0] nv;
    logic [7:0]  m0;
    logic [3:0]  m1;
    logic [2:0]  ef;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 req", irq_req, 0);
    for (int a = 0; a < 4; a++) begin rd(2'(a), d); chk("R1 reg", d, 0); end

    // R12 readback
    wr(0, 8'hFF); rd(0, d); chk("R12 ctrl", d, 8'h1F);
    wr(0, 8'h00);
    wr(1, 8'hA5); rd(1, d); chk("R12 mask0", d, 8'hA5);
    wr(2, 8'hFF); rd(2, d); chk("R12 mask1", d, 8'h0F);
    settle(); wr(3, 8'h07);

    // R3 masked pin ignored, R2 unmasked pin flags
    wr(1, 8'h01); wr(2, 8'h00); wr(0, 8'h02);
    pc_pins[1] = 1'b1; settle();
    rd(3, d); chk("R3 flags", d, 0); chk("R3 req", irq_req, 0);
    pc_pins[0] = 1'b1; settle();
    rd(3, d); chk("R2 flags", d, 8'h02);
    chk("R2 req", irq_req, 1); chk("R2 vec", irq_vec, 1);
    wr(3, 8'h02); rd(3, d); chk("R9 w1c", d, 0); chk("R9 req", irq_req, 0);

    // R11 flag sets without enable
    wr(0, 8'h00); pc_pins[0] = 1'b0; settle();
    rd(3, d); chk("R11 flag", d, 8'h02); chk("R11 req", irq_req, 0);
    wr(3, 8'h07);

    // R4 group 1, R9 ack
    wr(2, 8'h04); wr(0, 8'h04);
    pc_pins[10] = 1'b1; settle();
    rd(3, d); chk("R4 flags", d, 8'h04); chk("R4 vec", irq_vec, 2);
    chk("R4 req", irq_req, 1);
    ack(); rd(3, d); chk("R9 ack", d, 0); chk("R9 ack req", irq_req, 0);

    // R8 pin-change with I/O clock off
    io_clk_en = 1'b0; pc_pins[10] = 1'b0; settle();
    rd(3, d); chk("R8 flags", d, 8'h04);
    wr(3, 8'h07); io_clk_en = 1'b1;

    // R5 low level
    wr(0, 8'h01);
    io_clk_en = 1'b0; ext_pin = 1'b0; repeat (3) @(negedge clk);
    chk("R5 req low", irq_req, 1); chk("R5 vec", irq_vec, 0);
    ack(); chk("R5 ack kept", irq_req, 1);
    rd(3, d); chk("R5 no flag", d, 0);
    ext_pin = 1'b1; repeat (3) @(negedge clk);
    chk("R5 released", irq_req, 0);
    io_clk_en = 1'b1;

    // R6 falling, rising, any
    wr(0, 8'h11); ext_pin = 1'b0; settle();
    rd(3, d); chk("R6 fall hit", d, 8'h01); chk("R6 fall vec", irq_vec, 0);
    wr(3, 8'h01); ext_pin = 1'b1; settle();
    rd(3, d); chk("R6 fall miss", d, 0);
    wr(0, 8'h19); ext_pin = 1'b0; settle();
    rd(3, d); chk("R6 rise miss", d, 0);
    ext_pin = 1'b1; settle();
    rd(3, d); chk("R6 rise hit", d, 8'h01);
    wr(3, 8'h01); wr(0, 8'h09); ext_pin = 1'b0; settle();
    rd(3, d); chk("R6 any fall", d, 8'h01);
    wr(3, 8'h01); ext_pin = 1'b1; settle();
    rd(3, d); chk("R6 any rise", d, 8'h01);
    wr(3, 8'h01);

    // R7 edge lost while I/O clock off
    wr(0, 8'h11); io_clk_en = 1'b0; ext_pin = 1'b0; settle();
    rd(3, d); chk("R7 gated", d, 0);
    io_clk_en = 1'b1; settle();
    rd(3, d); chk("R7 after enable", d, 0); chk("R7 req", irq_req, 0);

    // R10 priority
    wr(1, 8'h01); wr(2, 8'h01); wr(0, 8'h1F);
    ext_pin = 1'b1; pc_pins[0] = 1'b1; pc_pins[8] = 1'b1; settle();
    chk("R10 first", irq_vec, 0); ack();
    chk("R10 second", irq_vec, 1); ack();
    chk("R10 third", irq_vec, 2); ack();
    chk("R10 none", irq_req, 0);

    // random pin-change traffic on both groups (R2, R4)
    wr(0, 8'h06);
    for (int it = 0; it < 40; it++) begin
      m0 = 8'($urandom); m1 = 4'($urandom);
      wr(1, m0); wr(2, {4'h0, m1}); wr(3, 8'h07);
      nv = 12'($urandom);
      ef = exp_grp(pc_pins, nv, m0, m1);
      pc_pins = nv; settle();
      rd(3, d); chk("R2 R4 random flags", d, {5'b0, ef});
      chk("R2 R4 random req", irq_req, |ef);
      if (|ef) chk("R10 random vec", irq_vec, exp_vec(ef));
    end

    done = 1'b1;
    finish_run();
  end
endmodule